// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block sits beside an SDRAM command path and follows the power condition of one device. Each clock it looks at the clock-enable level, the registered level from the cycle before, the active-low command pins, and a single input that says whether every bank is closed. From these it decides whether the device stays where it is, enters or leaves a low-power state, or has been given a command that the current state does not allow.

Five states are tracked: all banks idle, a generic active state (at least one bank open), clock suspend, power down and self refresh. The block reports the current state as a code. It also gives one-cycle strobes when self refresh or power down is entered or left, when a CBR refresh or mode-register load is accepted, and when a command is illegal. A controller or a protocol monitor uses these to keep its own view of the device in step, or to catch sequencing mistakes.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After reset the state code is 0 (all banks idle), every strobe is low, and the previous clock-enable is taken as high, so a first cycle with clock-enable low and no-operation enters power down.
- R2: Commands are decoded from active-low pins: chip select high is deselect whatever the other pins are; with chip select low, RAS/CAS/WE = 1/1/1 is no-operation, 0/0/1 is auto-refresh, 0/0/0 is mode-register set, and any other pattern is some other command.
- R3: In the idle or active state with clock-enable high on both cycles and all banks idle, auto-refresh gives a cbr_pulse and mode-register set gives a mode_pulse. The next state is 0 (idle) if all banks are idle and 1 (active) if not.
- R4: In the idle or active state, clock-enable high then low with all banks idle enters self refresh (code 4, sref_enter) on auto-refresh. It enters power down (code 3, pdn_enter) on deselect or no-operation. Any other command is flagged illegal and moves to clock suspend (code 2).
- R5: With a bank open and the previous clock-enable high, auto-refresh or mode-register set is flagged illegal. It gives no cbr_pulse, mode_pulse or entry strobe, and moves to code 1 if clock-enable stays high or code 2 if it falls.
- R6: In self refresh or power down, a previous clock-enable of high is flagged illegal and the state is kept.
- R7: In self refresh or power down, clock-enable low on both cycles keeps the state with no illegal flag and no strobe, for any command.
- R8: In self refresh or power down, clock-enable low then high with deselect or no-operation moves to idle (code 0) with sref_exit or pdn_exit, respectively.
- R9: In self refresh or power down, clock-enable low then high with any other command is flagged illegal and the state is kept.
- R10: From the active state, clock-enable high then low enters clock suspend (code 2) with no flag for commands other than auto-refresh and mode-register set. Clock-enable low keeps it there, and clock-enable high returns to code 0 or 1 by the bank-idle input.
- R11: All outputs are registered: they show the result of the inputs in the cycle before. Every strobe lasts one cycle, and at most one of the six event strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | High when every bank is closed |
| state_code | output | 3 | 0 idle, 1 active, 2 suspend, 3 power down, 4 self refresh |
| illegal | output | 1 | One-cycle pulse on an illegal or invalid combination |
| sref_enter | output | 1 | Self refresh entered |
| sref_exit | output | 1 | Self refresh left |
| pdn_enter | output | 1 | Power down entered |
| pdn_exit | output | 1 | Power down left |
| cbr_pulse | output | 1 | CBR refresh accepted |
| mode_pulse | output | 1 | Mode-register load accepted |

## Verification
The case that is hardest to reach is a low-power state where the previous clock-enable is high. The only way in is to raise clock-enable with a forbidden command, which is flagged and leaves the device in place. The bench does exactly that, then holds clock-enable high for another cycle and drops it once more. Each of those cycles must again be flagged, and a later low-to-high edge with a no-operation must still give a clean exit.

// File: rtl/sdram_cke_pkg.sv
// Package: types shared by the clock-enable tracker and its checker.
// Assumes: state codes are visible at the port and must not be renumbered.
package sdram_cke_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        PST_IDLE    = 3'd0,
        PST_ACTIVE  = 3'd1,
        PST_SUSPEND = 3'd2,
        PST_PDOWN   = 3'd3,
        PST_SREF    = 3'd4
    } pwr_state_t;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_AREF,
        CMD_MRS,
        CMD_OTHER
    } cmd_t;

    typedef struct packed {
        logic illegal;
        logic sref_enter;
        logic sref_exit;
        logic pdn_enter;
        logic pdn_exit;
        logic cbr;
        logic mode_load;
    } evt_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: sdram_cmd_decode
// Turns active-low command pins into the small command set the tracker
// needs. Assumes pins are already synchronous to clk. Purely combinational.
module sdram_cmd_decode
    import sdram_cke_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    // Map the pin pattern onto a command (R2).
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b001:  cmd = CMD_AREF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cke_next.sv
// Module: sdram_cke_next
// Combinational transition rules: from the current power state, the previous
// and current clock-enable, the decoded command and the bank-idle flag, it
// gives the next state and the events of this cycle. Holds no state.
module sdram_cke_next
    import sdram_cke_pkg::*;
(
    input  pwr_state_t cur,
    input  logic       prev_cke,
    input  logic       cke,
    input  cmd_t       cmd,
    input  logic       all_idle,
    output pwr_state_t nxt,
    output evt_t       ev
);

    logic       quiet;
    logic       restricted;
    pwr_state_t base;

    // Helper terms shared by every branch.
    always_comb begin
        quiet      = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
        restricted = (cmd == CMD_AREF) || (cmd == CMD_MRS);
        base       = all_idle ? PST_IDLE : PST_ACTIVE;
    end

    // Apply the clock-enable transition table for the current state.
    always_comb begin
        nxt = cur;
        ev  = '0;
        unique case (cur)
            PST_SREF, PST_PDOWN: begin
                if (prev_cke) begin
                    ev.illegal = 1'b1;                  // R6
                end else if (cke) begin
                    if (quiet) begin                    // R8
                        nxt = PST_IDLE;
                        if (cur == PST_SREF) ev.sref_exit = 1'b1;
                        else                 ev.pdn_exit  = 1'b1;
                    end else begin
                        ev.illegal = 1'b1;              // R9
                    end
                end
                // both low: hold silently (R7)
            end
            PST_SUSPEND: begin
                if (cke) nxt = base;                    // R10
            end
            default: begin                              // idle or active
                if (!prev_cke) begin
                    ev.illegal = 1'b1;
                    nxt = cke ? base : PST_SUSPEND;
                end else if (cke) begin                 // R3, R5
                    nxt = base;
                    if (restricted && !all_idle) ev.illegal   = 1'b1;
                    else if (cmd == CMD_AREF)    ev.cbr       = 1'b1;
                    else if (cmd == CMD_MRS)     ev.mode_load = 1'b1;
                end else if (all_idle) begin            // R4
                    if (cmd == CMD_AREF) begin
                        nxt = PST_SREF;
                        ev.sref_enter = 1'b1;
                    end else if (quiet) begin
                        nxt = PST_PDOWN;
                        ev.pdn_enter = 1'b1;
                    end else begin
                        nxt = PST_SUSPEND;
                        ev.illegal = 1'b1;
                    end
                end else begin                          // R5, R10
                    nxt = PST_SUSPEND;
                    ev.illegal = restricted;
                end
            end
        endcase
    end

endmodule

// File: rtl/sdram_cke_tracker.sv
// Module: sdram_cke_tracker (top)
// Follows the power state of one SDRAM device from clock-enable and command
// pins. Registers the previous clock-enable, the state and all event strobes.
// Assumes all_idle is valid in the same cycle as the command it qualifies.
module sdram_cke_tracker
    import sdram_cke_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cke,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                all_idle,
    output logic [STATE_W-1:0]  state_code,
    output logic                illegal,
    output logic                sref_enter,
    output logic                sref_exit,
    output logic                pdn_enter,
    output logic                pdn_exit,
    output logic                cbr_pulse,
    output logic                mode_pulse
);

    cmd_t       cmd;
    pwr_state_t cur_q;
    pwr_state_t nxt;
    logic       prev_cke_q;
    evt_t       ev;
    evt_t       ev_q;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_cke_next u_next (
        .cur      (cur_q),
        .prev_cke (prev_cke_q),
        .cke      (cke),
        .cmd      (cmd),
        .all_idle (all_idle),
        .nxt      (nxt),
        .ev       (ev)
    );

    // Hold state, previous clock-enable and event strobes (R1, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= PST_IDLE;
            prev_cke_q <= 1'b1;
            ev_q       <= '0;
        end else begin
            cur_q      <= nxt;
            prev_cke_q <= cke;
            ev_q       <= ev;
        end
    end

    // Drive ports from the registered values.
    always_comb begin
        state_code = cur_q;
        illegal    = ev_q.illegal;
        sref_enter = ev_q.sref_enter;
        sref_exit  = ev_q.sref_exit;
        pdn_enter  = ev_q.pdn_enter;
        pdn_exit   = ev_q.pdn_exit;
        cbr_pulse  = ev_q.cbr;
        mode_pulse = ev_q.mode_load;
    end

endmodule

// File: rtl/sdram_cke_tracker_chk.sv
// Module: sdram_cke_tracker_chk
// Port-level properties of the tracker, bound into every instance.
module sdram_cke_tracker_chk
    import sdram_cke_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cke,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic               all_idle,
    input logic [STATE_W-1:0] state_code,
    input logic               illegal,
    input logic               sref_enter,
    input logic               sref_exit,
    input logic               pdn_enter,
    input logic               pdn_exit,
    input logic               cbr_pulse,
    input logic               mode_pulse
);

    logic pin_aref;
    logic pin_mrs;
    logic low_power;

    // Pin-level view of the restricted commands.
    always_comb begin
        pin_aref  = !cs_n && !ras_n && !cas_n && we_n;
        pin_mrs   = !cs_n && !ras_n && !cas_n && !we_n;
        low_power = (state_code == 3'd3) || (state_code == 3'd4);
    end

    assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sref_enter, sref_exit, pdn_enter, pdn_exit, cbr_pulse, mode_pulse}));

    assert_sref_entry_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sref_enter |-> (state_code == 3'd4));

    assert_exit_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sref_exit || pdn_exit) |-> (state_code == 3'd0));

    assert_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !cke && !$past(cke)) |=> ($stable(state_code) && !illegal));

    assert_bank_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code <= 3'd1) && !all_idle && $past(cke) && (pin_aref || pin_mrs))
        |=> (illegal && !sref_enter && !cbr_pulse && !mode_pulse));

    assert_reset_state_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (state_code == 3'd0 && !illegal));

endmodule

bind sdram_cke_tracker sdram_cke_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .all_idle   (all_idle),
    .state_code (state_code),
    .illegal    (illegal),
    .sref_enter (sref_enter),
    .sref_exit  (sref_exit),
    .pdn_enter  (pdn_enter),
    .pdn_exit   (pdn_exit),
    .cbr_pulse  (cbr_pulse),
    .mode_pulse (mode_pulse)
);

// File: tb/tb_sdram_cke_tracker.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_sdram_cke_tracker;

    localparam int CLK_PERIOD = 10;

    // Command selectors for the drive task (pin patterns per R2).
    localparam int C_DESEL = 0;
    localparam int C_NOP   = 1;
    localparam int C_AREF  = 2;
    localparam int C_MRS   = 3;
    localparam int C_OTHER = 4;

    // Expected strobe vector order: illegal, sref_enter, sref_exit,
    // pdn_enter, pdn_exit, cbr_pulse, mode_pulse.
    localparam logic [6:0] F_NONE = 7'b0000000;
    localparam logic [6:0] F_ILL  = 7'b1000000;
    localparam logic [6:0] F_SEN  = 7'b0100000;
    localparam logic [6:0] F_SEX  = 7'b0010000;
    localparam logic [6:0] F_PEN  = 7'b0001000;
    localparam logic [6:0] F_PEX  = 7'b0000100;
    localparam logic [6:0] F_CBR  = 7'b0000010;
    localparam logic [6:0] F_MRS  = 7'b0000001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic       all_idle = 1'b1;
    logic [2:0] state_code;
    logic       illegal, sref_enter, sref_exit, pdn_enter, pdn_exit;
    logic       cbr_pulse, mode_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cke_tracker dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .all_idle(all_idle),
        .state_code(state_code), .illegal(illegal), .sref_enter(sref_enter),
        .sref_exit(sref_exit), .pdn_enter(pdn_enter), .pdn_exit(pdn_exit),
        .cbr_pulse(cbr_pulse), .mode_pulse(mode_pulse)
    );

    task automatic check(input string tag, input logic [2:0] exp_st,
                         input logic [6:0] exp_fl);
        logic [6:0] act_fl;
        act_fl = {illegal, sref_enter, sref_exit, pdn_enter, pdn_exit,
                  cbr_pulse, mode_pulse};
        total++;
        if (state_code !== exp_st || act_fl !== exp_fl) begin
            bad++;
            $display("FAIL %s: state=%0d flags=%b expected state=%0d flags=%b",
                     tag, state_code, act_fl, exp_st, exp_fl);
        end
    endtask

    // Drive one cycle of inputs after a falling edge, sample after the next rise.
    task automatic step(input logic k, input int c, input logic idle);
        @(negedge clk);
        cke = k;
        all_idle = idle;
        case (c)
            C_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1000;
            C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            C_AREF:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            C_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cke = 1'b1;
        all_idle = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 reset state", 3'd0, F_NONE);
        step(1'b0, C_NOP, 1'b1);
        check("R1 prev cke high after reset, enters power down", 3'd3, F_PEN);
    endtask

    task automatic t_refresh_and_mode();
        do_reset();
        step(1'b1, C_AREF, 1'b1);
        check("R3 cbr refresh", 3'd0, F_CBR);
        step(1'b1, C_MRS, 1'b1);
        check("R3 mode load", 3'd0, F_MRS);
        step(1'b1, C_NOP, 1'b0);
        check("R3 bank open gives active", 3'd1, F_NONE);
        step(1'b1, C_AREF, 1'b1);
        check("R3 refresh from active once banks idle", 3'd0, F_CBR);
        step(1'b1, C_NOP, 1'b1);
        check("R11 cbr pulse lasts one cycle", 3'd0, F_NONE);
    endtask

    task automatic t_self_refresh();
        do_reset();
        step(1'b0, C_AREF, 1'b1);
        check("R4 self refresh entry", 3'd4, F_SEN);
        step(1'b0, C_MRS, 1'b1);
        check("R7 hold ignores mode command", 3'd4, F_NONE);
        step(1'b0, C_OTHER, 1'b0);
        check("R7 hold ignores other command", 3'd4, F_NONE);
        step(1'b1, C_OTHER, 1'b1);
        check("R9 bad exit command", 3'd4, F_ILL);
        step(1'b1, C_NOP, 1'b1);
        check("R6 previous cke high in self refresh", 3'd4, F_ILL);
        step(1'b0, C_NOP, 1'b1);
        check("R6 previous cke high then low", 3'd4, F_ILL);
        step(1'b1, C_NOP, 1'b1);
        check("R8 self refresh exit on nop", 3'd0, F_SEX);
        step(1'b1, C_NOP, 1'b1);
        check("R11 exit strobe one cycle", 3'd0, F_NONE);
    endtask

    task automatic t_power_down();
        do_reset();
        step(1'b0, C_DESEL, 1'b1);
        check("R2 deselect ignores other pins, R4 power down entry", 3'd3, F_PEN);
        step(1'b0, C_AREF, 1'b1);
        check("R7 power down hold ignores refresh", 3'd3, F_NONE);
        step(1'b1, C_MRS, 1'b1);
        check("R9 power down bad exit", 3'd3, F_ILL);
        step(1'b0, C_NOP, 1'b1);
        check("R6 previous cke high in power down", 3'd3, F_ILL);
        step(1'b1, C_DESEL, 1'b1);
        check("R8 power down exit on deselect", 3'd0, F_PEX);
    endtask

    task automatic t_bank_open();
        do_reset();
        step(1'b1, C_NOP, 1'b0);
        check("R5 setup active", 3'd1, F_NONE);
        step(1'b1, C_MRS, 1'b0);
        check("R5 mode set with bank open", 3'd1, F_ILL);
        step(1'b1, C_AREF, 1'b0);
        check("R5 refresh with bank open", 3'd1, F_ILL);
        step(1'b0, C_AREF, 1'b0);
        check("R5 self refresh attempt with bank open", 3'd2, F_ILL);
    endtask

    task automatic t_suspend();
        do_reset();
        step(1'b1, C_NOP, 1'b0);
        check("R10 setup active", 3'd1, F_NONE);
        step(1'b0, C_OTHER, 1'b0);
        check("R10 suspend entry", 3'd2, F_NONE);
        step(1'b0, C_MRS, 1'b0);
        check("R10 suspend hold", 3'd2, F_NONE);
        step(1'b1, C_NOP, 1'b0);
        check("R10 suspend exit to active", 3'd1, F_NONE);
        step(1'b0, C_OTHER, 1'b1);
        check("R4 other command on falling cke with banks idle", 3'd2, F_ILL);
        step(1'b1, C_NOP, 1'b1);
        check("R10 suspend exit to idle", 3'd0, F_NONE);
    endtask

    initial begin
        t_reset();
        t_refresh_and_mode();
        t_self_refresh();
        t_power_down();
        t_bank_open();
        t_suspend();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule